// File: doc/BRIEF.md
# Split Fast/Normal Interrupt Controller

The controller gathers sixteen interrupt sources into a pending register and keeps a separate enable mask. Two processor request lines come out of it: a fast request line served by sources 0 to 3, which are the four highest-priority sources, and a normal request line served by sources 4 to 15. Some sources are edge events that latch until an end-of-interrupt strobe clears them. The other sources are levels that the pending register tracks directly. A compile-time parameter picks which bits latch. By default sources 8 to 11 latch: the two timers, the clock-match event and the tick.

Software reaches the block through four word registers.
- Offset 0 is the status view and offset 1 is the raw view. Both return the pending bits.
- A write to offset 2 sets enable bits.
- A write to offset 3 clears enable bits.

Both enable writes are qualified by byte lanes. Per-source clear strobes come from the peripherals' end-of-interrupt logic. The controller does no priority encoding and no vectoring inside either line.

Top module: `irq_split_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the pending bits, the enable mask, `fiq_o` and `irq_o` all become zero.
- R2: A latched source (bits 8–11 by default) sets its pending bit at the edge where its `src_in` bit is high. The bit then holds until an edge where its `eoi_clr` bit is high and its `src_in` bit is low.
- R3: A level source (every bit outside the latched set) shows at each edge the value its `src_in` bit had. Its `eoi_clr` bit has no effect.
- R4: A latched source whose `src_in` and `eoi_clr` bits are both high at the same edge ends up pending.
- R5: A write to offset 2 ORs the write data into the mask, bit by bit. Mask bits 7:0 are gated by `bus_be[0]` and bits 15:8 by `bus_be[1]`. Data bits 31:16 are ignored.
- R6: A write to offset 3 clears every mask bit written as one, with the same lane gating as R5.
- R7: Reads at offsets 0 and 1 return the pending bits in 15:0. Offset 2 returns the mask. Offset 3 and any unmapped offset return zero. Bits 31:16 always read zero.
- R8: Writes to offsets 0 and 1 change neither the mask nor the pending bits.
- R9: `fiq_o` is registered. It is high in the cycle after one in which pending AND mask AND 0x000F is nonzero, and low otherwise.
- R10: `irq_o` is registered. It is high in the cycle after one in which pending AND mask AND 0xFFF0 is nonzero, and low otherwise.
- R11: A pending bit is recorded and readable whether or not it is enabled. Enabling it later raises its line one cycle after the mask changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 16 | Source inputs: set pulses for latched bits, levels for the others |
| eoi_clr | input | 16 | Per-source end-of-interrupt clear strobes |
| bus_wr_en | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word offset |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane enables |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The assertions watch every cycle for these behaviours:
- each line equals the previous cycle's enabled pending bits in its own range;
- a set pulse always leaves its latched bit pending, and a lone clear strobe empties it;
- level bits track their inputs;
- enable writes set or clear exactly the lane-qualified bits;
- writes to the status offsets leave the mask unchanged.

Only the directed scenarios can show the rest:
- the read-back values at each offset;
- the ignored upper data and lane bits;
- a masked source staying visible in status and raising its line once enabled;
- a reset in the middle of the run clearing state that was built up.

// File: rtl/irq_split_pkg.sv
// Package: register offsets and small helpers shared by the interrupt controller.
// Assumes a word-addressed register window of four entries starting at offset 0.
package irq_split_pkg;

    localparam int unsigned OFS_STATUS = 0;
    localparam int unsigned OFS_RAW    = 1;
    localparam int unsigned OFS_EN_SET = 2;
    localparam int unsigned OFS_EN_CLR = 3;

    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_RAW    = 2'd1,
        SEL_EN_SET = 2'd2,
        SEL_EN_CLR = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_src_bank.sv
// Module: pending register for the interrupt sources.
// Every bit is built either as a latched bit (set by a pulse, cleared by an
// end-of-interrupt strobe, where the set wins) or as a level bit (follows its
// input). LATCHED_MASK chooses the kind of each bit.
module irq_src_bank #(
    parameter int unsigned NUM_SRC      = 16,
    parameter logic [NUM_SRC-1:0] LATCHED_MASK = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] clr_in,
    output logic [NUM_SRC-1:0] pend
);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
        if (LATCHED_MASK[i]) begin : g_latched
            // Latched bit: a set pulse takes priority over a clear strobe.
            always_ff @(posedge clk) begin
                if (!rst_n)          pend[i] <= 1'b0;
                else if (src_in[i])  pend[i] <= 1'b1;
                else if (clr_in[i])  pend[i] <= 1'b0;
            end

            assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
                src_in[i] |=> pend[i]);
            assert_eoi_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_in[i] && !src_in[i]) |=> !pend[i]);
        end else begin : g_level
            // Level bit: sample the source each cycle; clear strobes are ignored.
            always_ff @(posedge clk) begin
                if (!rst_n) pend[i] <= 1'b0;
                else        pend[i] <= src_in[i];
            end

            assert_level_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
                rst_n |=> (pend[i] == $past(src_in[i])));
        end
    end

endmodule

// File: rtl/irq_enable_reg.sv
// Module: interrupt enable mask, changed only through set and clear strobes.
// Assumes set_stb and clr_stb never assert together (they decode from one address).
module irq_enable_reg #(
    parameter int unsigned NUM_SRC = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_stb,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] bits,
    output logic [NUM_SRC-1:0] mask
);

    // Apply a write-one-to-set or write-one-to-clear update to the mask.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= '0;
        else if (set_stb) mask <= mask | bits;
        else if (clr_stb) mask <= mask & ~bits;
    end

    assert_enable_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((mask & $past(bits)) == $past(bits)));
    assert_enable_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((mask & $past(bits)) == '0));

endmodule

// File: rtl/irq_line_drv.sv
// Module: one registered interrupt request line covering a contiguous range
// of source bits [LO_BIT..HI_BIT]. Assumes LO_BIT <= HI_BIT < NUM_SRC.
module irq_line_drv #(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned LO_BIT  = 0,
    parameter int unsigned HI_BIT  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    output logic               line
);

    logic [NUM_SRC-1:0] sel;

    // Build the bit-range selector for this line.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            sel[i] = (i >= LO_BIT) && (i <= HI_BIT);
        end
    end

    // Register the request so that the line is glitch-free.
    always_ff @(posedge clk) begin
        if (!rst_n) line <= 1'b0;
        else        line <= |(pend & mask & sel);
    end

endmodule

// File: rtl/irq_bus_if.sv
// Module: register decode. It turns writes into enable strobes with the
// lane-qualified data and forms combinational read data. Assumes NUM_SRC <= DATA_W.
module irq_bus_if
    import irq_split_pkg::*;
#(
    parameter int unsigned NUM_SRC = 16,
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    localparam int unsigned BE_W   = DATA_W / 8
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wdata,
    input  logic [BE_W-1:0]    be,
    input  logic [NUM_SRC-1:0] pend,
    input  logic [NUM_SRC-1:0] mask,
    output logic               set_stb,
    output logic               clr_stb,
    output logic [NUM_SRC-1:0] bits,
    output logic [DATA_W-1:0]  rdata
);

    logic               mapped;
    reg_sel_e           sel;
    logic [NUM_SRC-1:0] lanes;

    // Decode the word offset into a register select.
    always_comb begin
        mapped = (addr <= ADDR_W'(OFS_EN_CLR));
        sel    = reg_sel_e'(addr[1:0]);
    end

    // Expand the byte enables into per-bit lane qualifiers.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            lanes[i] = be[i / 8];
        end
        bits = wdata[NUM_SRC-1:0] & lanes;
    end

    // Raise the enable strobes; writes to the status views go nowhere.
    always_comb begin
        set_stb = wr_en && mapped && (sel == SEL_EN_SET);
        clr_stb = wr_en && mapped && (sel == SEL_EN_CLR);
    end

    // Select the read data for the current offset.
    always_comb begin
        rdata = '0;
        if (mapped) begin
            unique case (sel)
                SEL_STATUS: rdata[NUM_SRC-1:0] = pend;
                SEL_RAW:    rdata[NUM_SRC-1:0] = pend;
                SEL_EN_SET: rdata[NUM_SRC-1:0] = mask;
                SEL_EN_CLR: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_split_ctrl.sv
// Module: top of the split interrupt controller. Sources below FAST_CNT drive
// the fast request line and the rest drive the normal line. Assumes a
// synchronous active-low reset and the bus to be word-addressed.
module irq_split_ctrl
    import irq_split_pkg::*;
#(
    parameter int unsigned NUM_SRC  = 16,
    parameter int unsigned FAST_CNT = 4,
    parameter int unsigned ADDR_W   = 4,
    parameter int unsigned DATA_W   = 32,
    parameter logic [NUM_SRC-1:0] LATCHED_MASK = 16'h0F00,
    localparam int unsigned BE_W    = DATA_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] eoi_clr,
    input  logic               bus_wr_en,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic [BE_W-1:0]    bus_be,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               fiq_o,
    output logic               irq_o
);

    localparam logic [NUM_SRC-1:0] FAST_SEL = NUM_SRC'((1 << FAST_CNT) - 1);

    logic [NUM_SRC-1:0] pend;
    logic [NUM_SRC-1:0] mask;
    logic [NUM_SRC-1:0] wbits;
    logic               set_stb;
    logic               clr_stb;

    irq_src_bank #(.NUM_SRC(NUM_SRC), .LATCHED_MASK(LATCHED_MASK)) u_bank (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .clr_in(eoi_clr), .pend(pend)
    );

    irq_bus_if #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bus (
        .addr(bus_addr), .wr_en(bus_wr_en), .wdata(bus_wdata), .be(bus_be),
        .pend(pend), .mask(mask), .set_stb(set_stb), .clr_stb(clr_stb),
        .bits(wbits), .rdata(bus_rdata)
    );

    irq_enable_reg #(.NUM_SRC(NUM_SRC)) u_en (
        .clk(clk), .rst_n(rst_n), .set_stb(set_stb), .clr_stb(clr_stb),
        .bits(wbits), .mask(mask)
    );

    irq_line_drv #(.NUM_SRC(NUM_SRC), .LO_BIT(0), .HI_BIT(FAST_CNT-1)) u_fast (
        .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .line(fiq_o)
    );

    irq_line_drv #(.NUM_SRC(NUM_SRC), .LO_BIT(FAST_CNT), .HI_BIT(NUM_SRC-1)) u_norm (
        .clk(clk), .rst_n(rst_n), .pend(pend), .mask(mask), .line(irq_o)
    );

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (pend == '0 && mask == '0 && !fiq_o && !irq_o));
    assert_fast_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o == |($past(pend & mask) & FAST_SEL));
    assert_norm_line_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |($past(pend & mask) & ~FAST_SEL));
    assert_status_wr_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr <= ADDR_W'(OFS_RAW)) |=> $stable(mask));

endmodule

// File: tb/irq_split_ctrl_tb.sv
// Directed bench for irq_split_ctrl: one task per scenario, each checking itself.
module irq_split_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] src_in = '0;
    logic [15:0] eoi_clr = '0;
    logic        bus_wr_en = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic        fiq_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    irq_split_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_in(src_in), .eoi_clr(eoi_clr),
        .bus_wr_en(bus_wr_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_be(bus_be), .bus_rdata(bus_rdata), .fiq_o(fiq_o), .irq_o(irq_o)
    );

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] be);
        bus_addr = a; bus_wdata = d; bus_be = be; bus_wr_en = 1'b1;
        step();
        bus_wr_en = 1'b0; bus_be = '0; bus_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic clean();
        src_in = '0; eoi_clr = 16'hFFFF;
        step();
        eoi_clr = '0;
        wr(4'd3, 32'h0000_FFFF, 4'b0011);
        step(2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(4'd1, d); chk("R1", "pending", d, 32'h0);
        rd(4'd2, d); chk("R1", "mask", d, 32'h0);
        chk("R1", "fiq", 32'(fiq_o), 32'h0);
        chk("R1", "irq", 32'(irq_o), 32'h0);
    endtask

    task automatic t_latched();
        logic [31:0] d;
        src_in[8] = 1'b1; step(); src_in[8] = 1'b0;
        rd(4'd1, d); chk("R2", "latched set", d, 32'h0000_0100);
        step(3);
        rd(4'd0, d); chk("R2", "latched hold", d, 32'h0000_0100);
        eoi_clr[8] = 1'b1; step(); eoi_clr[8] = 1'b0;
        rd(4'd1, d); chk("R2", "latched eoi", d, 32'h0);
        clean();
    endtask

    task automatic t_level();
        logic [31:0] d;
        src_in[4] = 1'b1; step();
        rd(4'd1, d); chk("R3", "level high", d, 32'h0000_0010);
        eoi_clr[4] = 1'b1; step(); eoi_clr[4] = 1'b0;
        rd(4'd1, d); chk("R3", "eoi ignored", d, 32'h0000_0010);
        src_in[4] = 1'b0; step();
        rd(4'd1, d); chk("R3", "level low", d, 32'h0);
        clean();
    endtask

    task automatic t_setwins();
        logic [31:0] d;
        src_in[9] = 1'b1; eoi_clr[9] = 1'b1; step();
        src_in[9] = 1'b0; eoi_clr[9] = 1'b0;
        rd(4'd1, d); chk("R4", "set beats clear", d, 32'h0000_0200);
        clean();
    endtask

    task automatic t_enset();
        logic [31:0] d;
        wr(4'd2, 32'h0000_1234, 4'b0001);
        rd(4'd2, d); chk("R5", "low lane", d, 32'h0000_0034);
        wr(4'd2, 32'h0000_FF00, 4'b0010);
        rd(4'd2, d); chk("R5", "high lane", d, 32'h0000_FF34);
        wr(4'd2, 32'hFFFF_0000, 4'b1111);
        rd(4'd2, d); chk("R5", "upper data ignored", d, 32'h0000_FF34);
    endtask

    task automatic t_enclr();
        logic [31:0] d;
        wr(4'd3, 32'h0000_0F04, 4'b0011);
        rd(4'd2, d); chk("R6", "clear ones", d, 32'h0000_F030);
        wr(4'd3, 32'h0000_FF00, 4'b0001);
        rd(4'd2, d); chk("R6", "lane gated", d, 32'h0000_F030);
        wr(4'd3, 32'h0000_FFFF, 4'b0011);
        rd(4'd2, d); chk("R6", "clear all", d, 32'h0);
    endtask

    task automatic t_reads();
        logic [31:0] d;
        src_in[1] = 1'b1; step();
        wr(4'd2, 32'h0000_00A5, 4'b0001);
        rd(4'd0, d); chk("R7", "status", d, 32'h0000_0002);
        rd(4'd1, d); chk("R7", "raw", d, 32'h0000_0002);
        rd(4'd2, d); chk("R7", "mask", d, 32'h0000_00A5);
        rd(4'd3, d); chk("R7", "clear reg", d, 32'h0);
        rd(4'd5, d); chk("R7", "unmapped", d, 32'h0);
        clean();
    endtask

    task automatic t_status_wr();
        logic [31:0] d;
        wr(4'd2, 32'h0000_00FF, 4'b0011);
        src_in[10] = 1'b1; step(); src_in[10] = 1'b0;
        wr(4'd0, 32'h0000_FFFF, 4'b1111);
        wr(4'd1, 32'h0000_0000, 4'b1111);
        rd(4'd2, d); chk("R8", "mask kept", d, 32'h0000_00FF);
        rd(4'd1, d); chk("R8", "pending kept", d, 32'h0000_0400);
        clean();
    endtask

    task automatic t_fiq();
        wr(4'd2, 32'h0000_0001, 4'b0011);
        src_in[0] = 1'b1; step();
        chk("R9", "fiq before", 32'(fiq_o), 32'h0);
        step();
        chk("R9", "fiq raised", 32'(fiq_o), 32'h1);
        chk("R10", "irq quiet on fast src", 32'(irq_o), 32'h0);
        wr(4'd3, 32'h0000_0001, 4'b0001);
        chk("R9", "fiq lags mask", 32'(fiq_o), 32'h1);
        step();
        chk("R9", "fiq dropped", 32'(fiq_o), 32'h0);
        clean();
    endtask

    task automatic t_irq();
        wr(4'd2, 32'h0000_0100, 4'b0010);
        src_in[8] = 1'b1; step(); src_in[8] = 1'b0;
        chk("R10", "irq before", 32'(irq_o), 32'h0);
        step();
        chk("R10", "irq raised", 32'(irq_o), 32'h1);
        chk("R9", "fiq quiet on normal src", 32'(fiq_o), 32'h0);
        eoi_clr[8] = 1'b1; step(); eoi_clr[8] = 1'b0;
        chk("R10", "irq lags eoi", 32'(irq_o), 32'h1);
        step();
        chk("R10", "irq dropped", 32'(irq_o), 32'h0);
        clean();
    endtask

    task automatic t_masked();
        logic [31:0] d;
        src_in[14] = 1'b1; step(3);
        rd(4'd0, d); chk("R11", "masked still pending", d, 32'h0000_4000);
        chk("R11", "masked no irq", 32'(irq_o), 32'h0);
        wr(4'd2, 32'h0000_4000, 4'b0010);
        chk("R11", "irq one cycle later", 32'(irq_o), 32'h0);
        step();
        chk("R11", "irq after enable", 32'(irq_o), 32'h1);
        src_in[14] = 1'b0;
    endtask

    task automatic t_midreset();
        logic [31:0] d;
        src_in[11] = 1'b1; step(); src_in[11] = 1'b0;
        wr(4'd2, 32'h0000_FFFF, 4'b0011);
        step();
        rst_n = 1'b0; step(2); rst_n = 1'b1;
        rd(4'd1, d); chk("R1", "pending after reset", d, 32'h0);
        rd(4'd2, d); chk("R1", "mask after reset", d, 32'h0);
        chk("R1", "lines after reset", {30'h0, fiq_o, irq_o}, 32'h0);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        t_reset();
        t_latched();
        t_level();
        t_setwins();
        t_enset();
        t_enclr();
        t_reads();
        t_status_wr();
        t_fiq();
        t_irq();
        t_masked();
        t_midreset();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule